// File: doc/BRIEF.md
# Push-Button Brightness Controller

This block holds a brightness level and changes it in response to four push-buttons: one that turns the light off, one that steps it up, one that steps it down, and one that drives it to full brightness. Pressing a button only arms the controller and raises a "button held" indicator. The chosen change is applied once, on the clock edge where every button has been let go. A lamp driver downstream reads the level output.

The buttons are assumed to be already debounced and synchronous to the clock. If more than one button is seen during a single hold, the highest-ranked one wins. This includes a button that joins after the hold has begun. The ranking from highest to lowest is off, full, up, down. Up and down steps stop at the range limits and do not wrap.

Top module: `dimmer_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `level_o` is 0 and `press_o` is 0. A reset during a hold discards the pending action.
- R2: `press_o` goes high on the first rising clock edge at which any button input is high, and stays high on every edge at which at least one button is still high.
- R3: `level_o` does not change while a hold is in progress. It changes only on the edge at which all buttons are low after a hold, and `press_o` returns to 0 on that same edge.
- R4: A hold whose winning button is off (`btn_off_i`) sets the level to 0.
- R5: A hold whose winning button is full (`btn_on_i`) sets the level to its maximum, 2^LEVEL_W-1, which is 15 for the default LEVEL_W of 4.
- R6: A hold whose winning button is up (`btn_up_i`) adds 1 to the level, and leaves it at the maximum if it is already there.
- R7: A hold whose winning button is down (`btn_dn_i`) subtracts 1 from the level, and leaves it at 0 if it is already there.
- R8: Each hold applies exactly one action, whatever its length. The level stays unchanged on the edges that follow the release until a new press.
- R9: Among all buttons seen high at any point during one hold, the action follows the ranking off, then full, then up, then down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_off_i | input | 1 | Off button, high while pressed |
| btn_up_i | input | 1 | Step-up button, high while pressed |
| btn_dn_i | input | 1 | Step-down button, high while pressed |
| btn_on_i | input | 1 | Full-brightness button, high while pressed |
| press_o | output | 1 | High while a button hold is in progress |
| level_o | output | LEVEL_W | Current brightness level |

## Verification
The bench steps the level against both limits. A design that wraps would show 0 after an up step from 15, or 15 after a down step from 0. It also holds a button for many cycles: a design that acts on press, or that repeats the action, would move the level before the release or more than once. Buttons are pressed together, and a higher-ranked button is added partway through a hold. A design that latches only the first button, or that ranks the buttons wrongly, would apply the lower-ranked action. A reset in the middle of a hold checks that the pending action is dropped and not applied on the later release.

// File: rtl/dimmer_pkg.sv
package dimmer_pkg;

  // Button vector bit positions
  localparam int unsigned BTN_OFF = 0;
  localparam int unsigned BTN_UP  = 1;
  localparam int unsigned BTN_DN  = 2;
  localparam int unsigned BTN_ON  = 3;
  localparam int unsigned BTN_N   = 4;

  // Encoded so that a larger value means a higher rank
  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_DEC  = 3'd1,
    ACT_INC  = 3'd2,
    ACT_MAX  = 3'd3,
    ACT_CLR  = 3'd4
  } act_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } hold_st_e;

  // Highest-ranked action among the buttons that are high now
  function automatic act_e act_from_buttons(input logic [BTN_N-1:0] b);
    act_e a;
    if (b[BTN_OFF])     a = ACT_CLR;
    else if (b[BTN_ON]) a = ACT_MAX;
    else if (b[BTN_UP]) a = ACT_INC;
    else if (b[BTN_DN]) a = ACT_DEC;
    else                a = ACT_NONE;
    return a;
  endfunction

  // Keep whichever of two actions ranks higher
  function automatic act_e act_merge(input act_e a, input act_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dimmer_hold_fsm.sv
module dimmer_hold_fsm
  import dimmer_pkg::*;
#(
  parameter int unsigned N_BTN = BTN_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_BTN-1:0] btn_i,
  output logic             held_o,
  output logic             press_evt_o,
  output logic             release_evt_o,
  output act_e             act_o
);

  hold_st_e st_q, st_d;
  act_e     act_q, act_d;
  logic     any_btn;
  act_e     cur_act;

  assign any_btn = |btn_i;
  assign cur_act = act_from_buttons(btn_i);

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    unique case (st_q)
      ST_IDLE: begin
        if (any_btn) begin
          st_d  = ST_HELD;
          act_d = cur_act;
        end
      end
      ST_HELD: begin
        if (any_btn) begin
          act_d = act_merge(act_q, cur_act);
        end else begin
          st_d  = ST_IDLE;
          act_d = ACT_NONE;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        act_d = ACT_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      act_q <= ACT_NONE;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
    end
  end

  assign held_o        = (st_q == ST_HELD);
  assign press_evt_o   = (st_q == ST_IDLE) && any_btn;
  assign release_evt_o = (st_q == ST_HELD) && !any_btn;
  assign act_o         = act_q;

endmodule

// File: rtl/dimmer_level_reg.sv
module dimmer_level_reg
  import dimmer_pkg::*;
#(
  parameter int unsigned LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply_i,
  input  act_e               act_i,
  output logic [LEVEL_W-1:0] level_o
);

  localparam logic [LEVEL_W-1:0] LVL_MAX  = {LEVEL_W{1'b1}};
  localparam logic [LEVEL_W-1:0] LVL_ZERO = '0;
  localparam logic [LEVEL_W-1:0] LVL_ONE  = LEVEL_W'(1);

  logic [LEVEL_W-1:0] lvl_q;

  // Saturating level update for one action
  function automatic logic [LEVEL_W-1:0] level_next(
    input logic [LEVEL_W-1:0] cur,
    input act_e               a
  );
    logic [LEVEL_W-1:0] r;
    unique case (a)
      ACT_CLR: r = LVL_ZERO;
      ACT_MAX: r = LVL_MAX;
      ACT_INC: r = (cur == LVL_MAX)  ? cur : cur + LVL_ONE;
      ACT_DEC: r = (cur == LVL_ZERO) ? cur : cur - LVL_ONE;
      default: r = cur;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lvl_q <= LVL_ZERO;
    else if (apply_i) lvl_q <= level_next(lvl_q, act_i);
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/dimmer_ctrl.sv
module dimmer_ctrl
  import dimmer_pkg::*;
#(
  parameter int unsigned LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_off_i,
  input  logic               btn_up_i,
  input  logic               btn_dn_i,
  input  logic               btn_on_i,
  output logic               press_o,
  output logic [LEVEL_W-1:0] level_o
);

  logic [BTN_N-1:0] btn_vec;
  logic             btn_any;
  logic             press_evt;
  logic             release_evt;
  act_e             fire_act;

  always_comb begin
    btn_vec          = '0;
    btn_vec[BTN_OFF] = btn_off_i;
    btn_vec[BTN_UP]  = btn_up_i;
    btn_vec[BTN_DN]  = btn_dn_i;
    btn_vec[BTN_ON]  = btn_on_i;
  end

  assign btn_any = |btn_vec;

  dimmer_hold_fsm #(
    .N_BTN(BTN_N)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_i        (btn_vec),
    .held_o       (press_o),
    .press_evt_o  (press_evt),
    .release_evt_o(release_evt),
    .act_o        (fire_act)
  );

  dimmer_level_reg #(
    .LEVEL_W(LEVEL_W)
  ) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .apply_i(release_evt),
    .act_i  (fire_act),
    .level_o(level_o)
  );

endmodule

// File: rtl/dimmer_ctrl_chk.sv
module dimmer_ctrl_chk
  import dimmer_pkg::*;
#(
  parameter int unsigned LEVEL_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               btn_any,
  input logic               press_o,
  input logic [LEVEL_W-1:0] level_o,
  input logic               press_evt,
  input logic               release_evt,
  input act_e               fire_act
);

  localparam logic [LEVEL_W-1:0] LVL_MAX = {LEVEL_W{1'b1}};

  a_r2_press_rises: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt |=> press_o);

  a_r2_press_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (press_o && btn_any) |=> press_o);

  a_r3_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !release_evt |=> $stable(level_o));

  a_r3_press_falls: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !press_o);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && fire_act == ACT_CLR) |=> (level_o == '0));

  a_r5_full: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && fire_act == ACT_MAX) |=> (level_o == LVL_MAX));

  a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && fire_act == ACT_INC && level_o != LVL_MAX)
      |=> (level_o == $past(level_o) + 1'b1));

  a_r6_up_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && fire_act == ACT_INC && level_o == LVL_MAX)
      |=> (level_o == LVL_MAX));

  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && fire_act == ACT_DEC && level_o != '0)
      |=> (level_o == $past(level_o) - 1'b1));

  a_r7_down_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && fire_act == ACT_DEC && level_o == '0)
      |=> (level_o == '0));

  a_r8_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !release_evt);

  a_r9_action_known: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |-> (fire_act != ACT_NONE));

endmodule

bind dimmer_ctrl dimmer_ctrl_chk #(
  .LEVEL_W(LEVEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .btn_any    (btn_any),
  .press_o    (press_o),
  .level_o    (level_o),
  .press_evt  (press_evt),
  .release_evt(release_evt),
  .fire_act   (fire_act)
);

// File: tb/dimmer_ctrl_tb.sv
module dimmer_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW         = 4;
  localparam int LMAX       = (1 << LW) - 1;
  localparam int WATCHDOG   = 20000;

  // mask bits: 0 off, 1 up, 2 down, 3 full
  localparam logic [3:0] M_OFF = 4'b0001;
  localparam logic [3:0] M_UP  = 4'b0010;
  localparam logic [3:0] M_DN  = 4'b0100;
  localparam logic [3:0] M_ON  = 4'b1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    btns = 4'b0000;
  logic          press_o;
  logic [LW-1:0] level_o;

  int checks = 0;
  int errors = 0;
  int exp_lvl = 0;
  bit done = 0;
  int sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dimmer_ctrl #(.LEVEL_W(LW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_off_i(btns[0]),
    .btn_up_i (btns[1]),
    .btn_dn_i (btns[2]),
    .btn_on_i (btns[3]),
    .press_o  (press_o),
    .level_o  (level_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Bench-side model of the level change for one hold
  function automatic int model(input int cur, input logic [3:0] m);
    if (m[0])      return 0;
    else if (m[3]) return LMAX;
    else if (m[1]) return (cur >= LMAX) ? LMAX : cur + 1;
    else if (m[2]) return (cur <= 0) ? 0 : cur - 1;
    return cur;
  endfunction

  // Driver: hold 'first' for 'hold' cycles, OR-ing 'later' in after the first
  task automatic press_release(input logic [3:0] first, input logic [3:0] later,
                               input int hold, input string req);
    logic [3:0] seen;
    seen = first;
    btns = first;
    @(negedge clk);
    check(press_o === 1'b1, "R2", int'(press_o), 1);
    check(int'(level_o) == exp_lvl, "R3", int'(level_o), exp_lvl);
    for (int i = 1; i < hold; i++) begin
      if (later != 4'b0000) begin
        btns = first | later;
        seen = first | later;
      end
      @(negedge clk);
      check(press_o === 1'b1, "R2", int'(press_o), 1);
      check(int'(level_o) == exp_lvl, "R3", int'(level_o), exp_lvl);
    end
    exp_lvl = model(exp_lvl, seen);
    sb_q.push_back(exp_lvl);
    btns = 4'b0000;
    @(negedge clk);
    check(press_o === 1'b0, "R3", int'(press_o), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(int'(level_o) == exp_lvl, "R8", int'(level_o), exp_lvl);
    end
    $display("hold done (%s) level=%0d", req, exp_lvl);
  endtask

  // Monitor: when the hold ends, pop the expected level and compare
  initial begin
    bit prev_press = 0;
    forever begin
      @(negedge clk);
      if (rst_n && prev_press && !press_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8", int'(level_o), -1);
        end else begin
          int e;
          e = sb_q.pop_front();
          check(int'(level_o) == e, "R3 scoreboard", int'(level_o), e);
        end
      end
      prev_press = press_o;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(level_o) == 0, "R1", int'(level_o), 0);
    check(press_o === 1'b0, "R1", int'(press_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(level_o) == 0, "R1", int'(level_o), 0);
    check(press_o === 1'b0, "R1", int'(press_o), 0);

    press_release(M_UP, 4'b0000, 1, "R6");
    press_release(M_UP, 4'b0000, 2, "R6");
    press_release(M_UP, 4'b0000, 3, "R6");
    press_release(M_DN, 4'b0000, 2, "R7");
    press_release(M_ON, 4'b0000, 1, "R5");
    press_release(M_UP, 4'b0000, 2, "R6 saturate");
    press_release(M_OFF, 4'b0000, 2, "R4");
    press_release(M_DN, 4'b0000, 2, "R7 saturate");
    press_release(M_UP, 4'b0000, 12, "R8 long hold");
    press_release(M_UP | M_DN, 4'b0000, 1, "R9 up over down");
    press_release(M_ON | M_UP, 4'b0000, 2, "R9 full over up");
    press_release(M_OFF | M_ON, 4'b0000, 2, "R9 off over full");
    press_release(M_UP, 4'b0000, 1, "R6");
    press_release(M_UP, M_OFF, 4, "R9 late off");
    press_release(M_DN, M_ON, 3, "R9 late full");
    press_release(M_DN, 4'b0000, 1, "R7");
    press_release(M_ON, M_DN, 3, "R9 late low rank");

    // R1: reset during a hold drops the pending action
    btns = M_OFF;
    @(negedge clk);
    check(press_o === 1'b1, "R2", int'(press_o), 1);
    rst_n = 1'b0;
    #1;
    check(int'(level_o) == 0, "R1", int'(level_o), 0);
    check(press_o === 1'b0, "R1", int'(press_o), 0);
    btns = 4'b0000;
    exp_lvl = 0;
    @(negedge clk);
    rst_n = 1'b1;
    press_release(M_ON, 4'b0000, 2, "R5 after reset");
    btns = M_DN;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    btns = 4'b0000;
    rst_n = 1'b1;
    exp_lvl = 0;
    repeat (3) @(negedge clk);
    check(int'(level_o) == 0, "R1", int'(level_o), 0);
    check(press_o === 1'b0, "R1", int'(press_o), 0);
    check(sb_q.size() == 0, "R8", sb_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule